// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block sequences single-shot conversions of a successive-approximation analog-to-digital converter. It is driven from a simple 32-bit register bus. Software selects an input channel, sets the power bit and optionally the interrupt enable, all in one control write. The block then waits a programmable number of clock periods so the analog front end can settle. It then resolves the result one bit per clock, most significant bit first. For each bit it drives a trial code to an external DAC and reads back a single comparator decision. When the last bit is resolved, the block latches the result, sets an interrupt flag and, if enabled, raises a level interrupt.

Writing a control word with the power bit clear turns the converter off. The same write acknowledges the interrupt and abandons any conversion in flight. The analog parts (DAC, comparator, channel multiplexer and reference) sit outside the block. The bus and the converter share one clock.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. `irq`, `adc_pwr`, `dac_code` and the busy flag are all zero.
- R2: The register map is fixed.
  - Offset 0x00 holds the result, zero above RES_W.
  - Offset 0x04 is status, with bit 0 = busy.
  - Offset 0x08 is control: bits [2:0] channel, bit 3 power, bit 5 interrupt enable, bit 6 interrupt flag (read-only).
  - Offset 0x0C holds the delay count in bits [5:0].
  - All other offsets and bits read zero.
- R3: A control write with bit 3 set while idle starts a conversion. Busy reads 1 from the next cycle for exactly D+RES_W cycles, where D is the delay register value. `adc_pwr` is 1 whenever busy is 1.
- R4: `dac_code` is zero whenever no bit is being resolved. The first trial code (only the MSB set) appears exactly D cycles after busy rises, or in the first busy cycle when D is zero.
- R5: One bit is resolved per clock, MSB first. The trial code is the kept bits plus the bit under test. The bit is kept when `cmp_in` is 1 (input at or above the trial code). With an ideal comparator the result equals the input code, including all-zeros and all-ones inputs.
- R6: On completion, busy clears and the result is latched into the data register. The interrupt flag (control bit 6) is set, and `irq` equals flag AND enable.
- R7: A control write with bit 3 clear does all of the following from the next cycle:
  - clears busy, the flag, the data register and `adc_pwr`;
  - aborts any conversion, so the aborted conversion never sets the flag.
- R8: A control write with bit 3 set while busy changes only the interrupt enable. The channel and the running conversion continue unchanged.
- R9: A channel number at or above NUM_CH still takes the full conversion time but returns zero.
- R10: The result and flag hold until the next start or power-down. Reading any register has no side effect. A new start clears the flag and the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and converter |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |
| dac_code | output | RES_W | Trial code to the external DAC |
| ch_sel | output | 3 | Channel select to the input multiplexer |
| adc_pwr | output | 1 | Converter power enable |
| irq | output | 1 | Level interrupt |

## Verification
A wrong sequencer state shows up first as a busy flag that is one cycle early or late, or as a trial code on `dac_code` outside the approximation window. The bench checks both at the exact cycle where the requirements place them.

An error in the approximation register shows up in the latched result at completion, D+RES_W cycles after the start write. Each result is compared with the ideal comparator input for that channel. A flag or enable fault shows up on `irq` in the first idle cycle after completion, and also after abort and busy-time writes.

// File: rtl/sar_pkg.sv
// Shared constants and types for the SAR sequencing controller.
// Assumes a byte-addressed bus with word-aligned registers.
package sar_pkg;
    localparam int CH_W  = 3;
    localparam int DLY_W = 6;

    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_DLY  = 8'h0C;

    localparam int BIT_PWR  = 3;
    localparam int BIT_IEN  = 5;
    localparam int BIT_FLAG = 6;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_CONV = 2'd2
    } sq_state_t;
endpackage

// File: rtl/sar_regs.sv
// Register file and bus decode of the SAR controller.
// Holds control, delay, result and flag, and generates start/abort pulses.
// Assumes one write per cycle and combinational reads without side effects.
module sar_regs
    import sar_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int NUM_CH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic [RES_W-1:0]      result,
    output logic                  start,
    output logic                  abort,
    output logic [CH_W-1:0]       ch_q,
    output logic                  pwr_q,
    output logic                  ien_q,
    output logic [DLY_W-1:0]      dly_q,
    output logic [RES_W-1:0]      data_q,
    output logic                  flag_q,
    output logic                  irq
);
    logic ctrl_wr;
    logic in_range;
    logic unused_bits;

    assign unused_bits = ^{bus_wdata[31:7], bus_wdata[BIT_FLAG]};

    // Decode a control write into start and abort pulses.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
        start   = ctrl_wr && bus_wdata[BIT_PWR] && !busy;
        abort   = ctrl_wr && !bus_wdata[BIT_PWR];
    end

    // Flag out-of-range channels, whose result is forced to zero.
    assign in_range = (32'(ch_q) < NUM_CH);

    // Control fields: a busy-time write with power set only touches the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q  <= '0;
            pwr_q <= 1'b0;
            ien_q <= 1'b0;
        end else if (ctrl_wr) begin
            ien_q <= bus_wdata[BIT_IEN];
            if (!(busy && bus_wdata[BIT_PWR])) begin
                ch_q  <= bus_wdata[CH_W-1:0];
                pwr_q <= bus_wdata[BIT_PWR];
            end
        end
    end

    // Delay register, taken at the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= '0;
        else if (bus_wr && (bus_addr == OFS_DLY))
            dly_q <= bus_wdata[DLY_W-1:0];
    end

    // Result and flag: cleared at start or power-down, set at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            flag_q <= 1'b0;
        end else if (start || abort) begin
            data_q <= '0;
            flag_q <= 1'b0;
        end else if (done) begin
            data_q <= in_range ? result : '0;
            flag_q <= 1'b1;
        end
    end

    // Level interrupt.
    assign irq = flag_q && ien_q;

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA: bus_rdata[RES_W-1:0] = data_q;
            OFS_STAT: bus_rdata[0]         = busy;
            OFS_CTRL: begin
                bus_rdata[CH_W-1:0] = ch_q;
                bus_rdata[BIT_PWR]  = pwr_q;
                bus_rdata[BIT_IEN]  = ien_q;
                bus_rdata[BIT_FLAG] = flag_q;
            end
            OFS_DLY:  bus_rdata[DLY_W-1:0] = dly_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sar_seq.sv
// Conversion sequencer: power-up delay phase, then one bit per clock.
// Assumes start and abort never arrive together (the decoder keeps them exclusive).
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W = 10,
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] dly,
    output logic             busy,
    output logic             conv,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    sq_state_t        state;
    logic [DLY_W-1:0] cnt;

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

    // State, delay counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else if (abort) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    idx <= IDX_TOP;
                    if (dly == '0) begin
                        state <= SQ_CONV;
                    end else begin
                        state <= SQ_WAIT;
                        cnt   <= dly - 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (cnt == '0) state <= SQ_CONV;
                    else           cnt   <= cnt - 1'b1;
                end
                SQ_CONV: begin
                    if (idx == '0) state <= SQ_IDLE;
                    else           idx   <= idx - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Phase decode and completion pulse.
    always_comb begin
        busy = (state != SQ_IDLE);
        conv = (state == SQ_CONV);
        done = conv && (idx == '0) && !abort;
    end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register and trial-code generator.
// Assumes bits below the current index are zero, which the clear at start guarantees.
module sar_approx #(
    parameter int RES_W = 10,
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             conv,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] trial;

    // Per-bit trial code and next-value selection.
    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        logic hit;
        assign hit      = conv && (idx == IDX_W'(i));
        assign trial[i] = hit ? 1'b1   : sar_q[i];
        assign result[i] = hit ? cmp_in : sar_q[i];
    end

    // Trial code is driven only while a bit is being resolved.
    assign dac_code = conv ? trial : '0;

    // Register holding the decisions made so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sar_q <= '0;
        else if (clear)
            sar_q <= '0;
        else if (conv)
            sar_q <= result;
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
// Top of the SAR sequencing controller: registers, sequencer and approximation register.
// Assumes one clock for bus and converter; RES_W is 10 or 12; NUM_CH is 2 to 6.
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int NUM_CH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [CH_W-1:0]  ch_sel,
    output logic             adc_pwr,
    output logic             irq
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic             start_w, abort_w, busy_w, conv_w, done_w;
    logic             ien_w, flag_w;
    logic [IDX_W-1:0] idx_w;
    logic [DLY_W-1:0] dly_w;
    logic [RES_W-1:0] result_w, data_w;

    sar_regs #(.RES_W(RES_W), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy_w), .done(done_w), .result(result_w),
        .start(start_w), .abort(abort_w),
        .ch_q(ch_sel), .pwr_q(adc_pwr), .ien_q(ien_w), .dly_q(dly_w),
        .data_q(data_w), .flag_q(flag_w), .irq(irq)
    );

    sar_seq #(.RES_W(RES_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_w), .abort(abort_w), .dly(dly_w),
        .busy(busy_w), .conv(conv_w), .done(done_w), .idx(idx_w)
    );

    sar_approx #(.RES_W(RES_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .clear(start_w), .conv(conv_w), .idx(idx_w),
        .cmp_in(cmp_in), .dac_code(dac_code), .result(result_w)
    );
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
// Property checker for sar_seq_ctrl, attached by bind.
module sar_seq_ctrl_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [RES_W-1:0] dac_code,
    input logic [2:0]       ch_sel,
    input logic             adc_pwr,
    input logic             irq,
    input logic             busy,
    input logic [RES_W-1:0] data_q
);
    logic ctl_on, ctl_off;
    assign ctl_on  = bus_wr && (bus_addr == 8'h08) && bus_wdata[3];
    assign ctl_off = bus_wr && (bus_addr == 8'h08) && !bus_wdata[3];

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_on && !busy |=> busy);                                  // R3
    AST_PWR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> adc_pwr);                                          // R3
    AST_DAC_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dac_code == '0);                                  // R4
    AST_IRQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);                                             // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_off |=> !busy && !irq && !adc_pwr && data_q == '0);     // R7
    AST_BUSY_WR_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_on && busy |=> $stable(ch_sel));                        // R8
    AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(data_q));                   // R10
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dac_code(dac_code), .ch_sel(ch_sel),
    .adc_pwr(adc_pwr), .irq(irq), .busy(busy_w), .data_q(data_w)
);

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    localparam int RES_W = 10;
    localparam int NCH   = 3;
    localparam logic [RES_W-1:0] MSB  = 1 << (RES_W - 1);
    localparam logic [RES_W-1:0] ONES = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = 8'h00;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             cmp_in;
    logic [RES_W-1:0] dac_code;
    logic [2:0]       ch_sel;
    logic             adc_pwr, irq;
    logic [RES_W-1:0] vin [8];

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // Ideal comparator and channel multiplexer model
    assign cmp_in = (vin[ch_sel] >= dac_code);

    sar_seq_ctrl #(.RES_W(RES_W), .NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .ch_sel(ch_sel), .adc_pwr(adc_pwr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_result(input int ch);
        return (ch < NCH) ? 32'(vin[ch]) : 32'd0;
    endfunction

    function automatic logic [31:0] ctrl_word(input int ch, input bit pwr, input bit en);
        return (32'(en) << 5) | (32'(pwr) << 3) | 32'(ch);
    endfunction

    // Full conversion with cycle-exact checks of busy, first trial code and completion
    task automatic run_conv(input int ch, input int d, input bit en);
        logic [31:0] r;
        bus_write(8'h0C, 32'(d));
        bus_write(8'h08, ctrl_word(ch, 1, en));
        bus_read(8'h04, r);
        chk("R3 busy right after start", r, 32'd1);
        bus_read(8'h00, r);
        chk("R10 data cleared at start", r, 32'd0);
        if (d > 0) chk("R4 dac quiet during delay", 32'(dac_code), 32'd0);
        repeat (d) @(negedge clk);
        chk("R4 first trial code is MSB", 32'(dac_code), 32'(MSB));
        repeat (RES_W - 1) @(negedge clk);
        bus_read(8'h04, r);
        chk("R3 busy on last bit cycle", r, 32'd1);
        @(negedge clk);
        bus_read(8'h04, r);
        chk("R3 busy clear after D+RES cycles", r, 32'd0);
        bus_read(8'h00, r);
        chk(ch < NCH ? "R5 result equals input" : "R9 out-of-range channel reads zero",
            r, exp_result(ch));
        bus_read(8'h08, r);
        chk("R6 flag set in control bit 6", r, ctrl_word(ch, 1, en) | 32'h40);
        chk("R6 irq equals flag and enable", 32'(irq), 32'(en));
    endtask

    initial begin
        logic [31:0] r, r2;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) vin[i] = RES_W'($urandom);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a += 4) begin
            bus_read(8'(a), r);
            chk("R1 register zero after reset", r, 32'd0);
        end
        chk("R1 irq low", 32'(irq), 0);
        chk("R1 power low", 32'(adc_pwr), 0);
        chk("R1 dac zero", 32'(dac_code), 0);

        // R2 delay width and unmapped reads
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, r);
        chk("R2 delay masked to 6 bits", r, 32'h3F);
        bus_read(8'h10, r);
        chk("R2 unmapped offset reads zero", r, 32'd0);

        // R5 boundary inputs, zero delay
        vin[0] = '0;
        run_conv(0, 0, 1);
        vin[1] = ONES;
        run_conv(1, 8, 0);
        bus_read(8'h00, r);
        chk("R2 data zero above result width", r & ~32'(ONES), 32'd0);

        // R10 hold and read without side effects
        repeat (20) @(negedge clk);
        bus_read(8'h00, r);
        bus_read(8'h00, r2);
        chk("R10 result holds across reads", r2, 32'(ONES));
        bus_read(8'h08, r);
        chk("R10 flag holds", r & 32'h40, 32'h40);

        // R7 power-down clears flag and result
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, r);
        chk("R7 control cleared by zero write", r, 32'd0);
        bus_read(8'h00, r);
        chk("R7 data cleared by zero write", r, 32'd0);
        chk("R7 power off", 32'(adc_pwr), 0);

        // R7 abort mid conversion
        bus_write(8'h0C, 32'd4);
        bus_write(8'h08, ctrl_word(2, 1, 1));
        repeat (7) @(negedge clk);
        bus_write(8'h08, 32'h0);
        bus_read(8'h04, r);
        chk("R7 busy cleared by abort", r, 32'd0);
        repeat (RES_W + 6) @(negedge clk);
        bus_read(8'h08, r);
        chk("R7 aborted conversion sets no flag", r, 32'd0);
        chk("R7 no irq after abort", 32'(irq), 0);

        // R8 busy-time write changes enable only
        vin[1] = RES_W'($urandom);
        bus_write(8'h0C, 32'd2);
        bus_write(8'h08, ctrl_word(1, 1, 0));
        repeat (3) @(negedge clk);
        bus_write(8'h08, ctrl_word(5, 1, 1));
        bus_read(8'h08, r);
        chk("R8 channel kept, enable updated", r, ctrl_word(1, 1, 1));
        repeat (RES_W) @(negedge clk);
        bus_read(8'h00, r);
        chk("R8 conversion unaffected", r, exp_result(1));
        chk("R8 new enable drives irq", 32'(irq), 1);

        // Random conversions across channels, delays and enables
        for (int k = 0; k < 40; k++) begin
            int ch = int'($urandom % 8);
            int d  = int'($urandom % 12);
            bit en = 1'($urandom);
            vin[ch] = RES_W'($urandom);
            run_conv(ch, d, en);
            if ($urandom % 3 == 0) begin
                bus_write(8'h08, 32'h0);
                chk("R7 irq cleared by power-down", 32'(irq), 0);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule